// File: doc/BRIEF.md
# Boot-Time Configuration Retry Controller

This block is a single memory-mapped control register that gates host configuration traffic after power-up and holds the local processor cores in reset. While its retry-hold bit is set, a downstream responder answers every host configuration request with a retry status instead of servicing it. Firmware clears the hold once the device is ready to be enumerated.

The register's power-up contents come from strap pins. These are captured on every clock while the active-low reset is held, so the value present at the last clock before release is the one kept. A firmware watchdog, enabled by its own strap-loaded bit, releases the hold by itself if firmware is too slow. When that happens it also clears its enable bit. Software can then tell a timeout release (enable reads 0) from a firmware release (enable reads 1). Each core-reset bit can only be cleared by ordinary writes, and a separate write-one-to-set field turns a bit on again. An internal bus reset request reloads the core bits from the captured straps.

Top module: `boot_cfg_retry_ctrl`

## Requirements
- R1: While `rst_n` is 0, the register loads its defaults on every clock: bit 2 (hold) = `strap_retry`, bit 7 (watchdog enable) = `strap_tmr_en`, and core bit i (bits 1:0) = NOT `strap_core_n[i]`. These values remain after `rst_n` rises.
- R2: `cfg_retry` always equals the hold bit, which reads back at `rd_data[2]`. `core_rst` equals `rd_data[1:0]`.
- R3: With both the hold and enable bits at 1 since reset release, the hold bit and the enable bit both read 0 after exactly `TIMEOUT_CYC` clocks. After `TIMEOUT_CYC`-1 clocks the hold bit still reads 1.
- R4: A write with bit 2 = 0 and bit 7 = 1 before expiry clears the hold bit and leaves the enable bit at 1. The watchdog then stops and never clears anything.
- R5: With the enable bit at 0, the hold bit stays 1 indefinitely. Only a write with bit 2 = 0 clears it.
- R6: Core bits are clear-only. Writing 0 at bit i clears core bit i. Writing 1 there leaves it unchanged.
- R7: Writing 1 at bit 8+i sets core bit i, and this takes priority over a clear in the same write. Bits 9:8 always read 0.
- R8: `bus_rst_req` at 1 reloads the core bits with the defaults captured at reset. It takes priority over a write in the same cycle.
- R9: Bits 6:3 and bits 31:10 always read 0, whatever is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; straps captured while low |
| strap_retry | input | 1 | Strap default for the hold bit (1 = hold) |
| strap_tmr_en | input | 1 | Strap default for the watchdog enable bit |
| strap_core_n | input | NUM_CORES | Per-core strap, low = core starts in reset |
| bus_rst_req | input | 1 | Internal bus reset request; reloads core bits |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | REG_W | Register write data |
| rd_data | output | REG_W | Register read value |
| cfg_retry | output | 1 | 1 = answer host configuration requests with retry status |
| core_rst | output | NUM_CORES | 1 = hold core i in reset |

## Verification
The watchdog is tried with three patterns, each separating one release path from the others:
- Idle after release, which tells timeout release apart from a premature or missing one through the enable bit.
- An early firmware clear, which confirms the enable bit survives.
- A disabled strap, which proves the hold never lapses.

Core bits get write patterns that mix clear, keep and set in one word. One pattern has the bus reset collide with a write, which exposes any wrong priority.

A long seeded random run covers the register as a whole. It includes resets with random straps, and each cycle is compared with a bench model of the register.

// File: rtl/boot_cfg_pkg.sv
package boot_cfg_pkg;
   // Field positions decoded by software and the retry responder
   localparam int HOLD_BIT  = 2;
   localparam int WDOG_BIT  = 7;
   localparam int SET_LSB   = 8;
   localparam int USED_MSB  = 9;

   typedef struct packed {
      logic hold;
      logic wdog_en;
   } gate_t;
endpackage

// File: rtl/boot_strap_capture.sv
module boot_strap_capture #(
   parameter int NUM_CORES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_CORES-1:0] strap_core_n,
   output logic [NUM_CORES-1:0] def_core
);
   always_ff @(posedge clk) begin
      if (!rst_n) def_core <= ~strap_core_n;
   end
endmodule

// File: rtl/boot_fw_watchdog.sv
module boot_fw_watchdog #(
   parameter int TIMEOUT_CYC = 100_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic expire
);
   localparam int CNT_W = (TIMEOUT_CYC > 1) ? $clog2(TIMEOUT_CYC + 1) : 1;

   if (TIMEOUT_CYC < 1) begin : g_bad_timeout
      $error("TIMEOUT_CYC must be at least 1");
   end

   if (TIMEOUT_CYC == 1) begin : g_single
      assign expire = run;
   end else begin : g_count
      logic [CNT_W-1:0] cnt_q;
      localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYC - 1);

      assign expire = run && (cnt_q == LAST);

      always_ff @(posedge clk) begin
         if (!rst_n)                cnt_q <= '0;
         else if (run && !expire)   cnt_q <= cnt_q + 1'b1;
      end

      // R3
      cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
         cnt_q <= LAST);
      // R4
      cnt_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !run |=> cnt_q == $past(cnt_q));
   end
endmodule

// File: rtl/boot_core_reset_ctl.sv
module boot_core_reset_ctl #(
   parameter int NUM_CORES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_CORES-1:0] strap_core_n,
   input  logic [NUM_CORES-1:0] def_core,
   input  logic                 bus_rst_req,
   input  logic                 wr_en,
   input  logic [NUM_CORES-1:0] clr_keep,
   input  logic [NUM_CORES-1:0] set_mask,
   output logic [NUM_CORES-1:0] core_rst
);
   for (genvar i = 0; i < NUM_CORES; i++) begin : g_core
      logic q;
      always_ff @(posedge clk) begin
         if (!rst_n)            q <= ~strap_core_n[i];
         else if (bus_rst_req)  q <= def_core[i];
         else if (wr_en) begin
            if (set_mask[i])       q <= 1'b1;
            else if (!clr_keep[i]) q <= 1'b0;
         end
      end
      assign core_rst[i] = q;

      // R6
      no_sw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !q && !bus_rst_req && !(wr_en && set_mask[i]) |=> !q);
      // R7
      set_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
         wr_en && set_mask[i] && !bus_rst_req |=> q);
   end

   // R8
   bus_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rst_req |=> core_rst == $past(def_core));
endmodule

// File: rtl/boot_cfg_retry_ctrl.sv
module boot_cfg_retry_ctrl
   import boot_cfg_pkg::*;
#(
   parameter int REG_W       = 32,
   parameter int NUM_CORES   = 2,
   parameter int TIMEOUT_CYC = 100_000_000
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 strap_retry,
   input  logic                 strap_tmr_en,
   input  logic [NUM_CORES-1:0] strap_core_n,
   input  logic                 bus_rst_req,
   input  logic                 wr_en,
   input  logic [REG_W-1:0]     wr_data,
   output logic [REG_W-1:0]     rd_data,
   output logic                 cfg_retry,
   output logic [NUM_CORES-1:0] core_rst
);
   if (REG_W < USED_MSB + 1) begin : g_bad_width
      $error("REG_W too small for the register layout");
   end
   if (NUM_CORES < 1 || NUM_CORES > HOLD_BIT) begin : g_bad_cores
      $error("NUM_CORES must fit below the hold bit");
   end

   gate_t gate_q;
   logic  run, expire;
   logic  [NUM_CORES-1:0] def_core;

   boot_strap_capture #(.NUM_CORES(NUM_CORES)) u_straps (
      .clk(clk), .rst_n(rst_n), .strap_core_n(strap_core_n), .def_core(def_core));

   assign run = gate_q.hold && gate_q.wdog_en;

   boot_fw_watchdog #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_wdog (
      .clk(clk), .rst_n(rst_n), .run(run), .expire(expire));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gate_q.hold    <= strap_retry;
         gate_q.wdog_en <= strap_tmr_en;
      end else begin
         if (wr_en) begin
            gate_q.hold    <= wr_data[HOLD_BIT];
            gate_q.wdog_en <= wr_data[WDOG_BIT];
         end
         if (expire) begin
            gate_q.hold    <= 1'b0;
            gate_q.wdog_en <= 1'b0;
         end
      end
   end

   boot_core_reset_ctl #(.NUM_CORES(NUM_CORES)) u_cores (
      .clk(clk), .rst_n(rst_n), .strap_core_n(strap_core_n), .def_core(def_core),
      .bus_rst_req(bus_rst_req), .wr_en(wr_en),
      .clr_keep(wr_data[NUM_CORES-1:0]),
      .set_mask(wr_data[SET_LSB +: NUM_CORES]),
      .core_rst(core_rst));

   always_comb begin
      rd_data                 = '0;
      rd_data[NUM_CORES-1:0]  = core_rst;
      rd_data[HOLD_BIT]       = gate_q.hold;
      rd_data[WDOG_BIT]       = gate_q.wdog_en;
   end
   assign cfg_retry = gate_q.hold;

   // R3
   expiry_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> !cfg_retry && !rd_data[WDOG_BIT]);
   // R5
   hold_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_retry && !rd_data[WDOG_BIT] && !(wr_en && !wr_data[HOLD_BIT]) |=> cfg_retry);
   // R4
   enable_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[WDOG_BIT] && !expire && !(wr_en && !wr_data[WDOG_BIT]) |=> rd_data[WDOG_BIT]);
endmodule

// File: tb/sim_boot_cfg_retry_ctrl.sv
`timescale 1ns/1ps
module sim_boot_cfg_retry_ctrl;
   localparam int TMO = 40;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic s_retry = 1'b1, s_tmr = 1'b1;
   logic [1:0] s_core_n = 2'b01;
   logic bus_rst = 1'b0, wr_en = 1'b0;
   logic [31:0] wr_data = '0, rd_data;
   logic cfg_retry;
   logic [1:0] core_rst;
   int checks = 0, fails = 0, cyc = 0;
   bit model_on = 0;

   always #2 clk = ~clk;

   boot_cfg_retry_ctrl #(.REG_W(32), .NUM_CORES(2), .TIMEOUT_CYC(TMO)) u0 (
      .clk(clk), .rst_n(rst_n), .strap_retry(s_retry), .strap_tmr_en(s_tmr),
      .strap_core_n(s_core_n), .bus_rst_req(bus_rst), .wr_en(wr_en),
      .wr_data(wr_data), .rd_data(rd_data), .cfg_retry(cfg_retry), .core_rst(core_rst));

   // Bench model of the register, written from the requirements
   logic m_hold, m_en;
   logic [1:0] m_core, m_def;
   int m_cnt;
   always @(posedge clk) begin
      logic run, exp_now;
      run = m_hold && m_en;
      exp_now = run && (m_cnt == TMO - 1);
      if (!rst_n) begin
         m_hold <= s_retry; m_en <= s_tmr; m_core <= ~s_core_n; m_def <= ~s_core_n; m_cnt <= 0;
      end else begin
         if (exp_now) begin m_hold <= 1'b0; m_en <= 1'b0; end
         else if (wr_en) begin m_hold <= wr_data[2]; m_en <= wr_data[7]; end
         if (run && !exp_now) m_cnt <= m_cnt + 1;
         if (bus_rst) m_core <= m_def;
         else if (wr_en) m_core <= (m_core & wr_data[1:0]) | wr_data[9:8];
      end
   end

   function automatic logic [31:0] exp_rd(logic h, logic e, logic [1:0] c);
      return {24'd0, e, 4'd0, h, c};
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wait_cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset(logic r, logic t, logic [1:0] cn);
      rst_n = 1'b0; s_retry = r; s_tmr = t; s_core_n = cn;
      wait_cyc(3);
      rst_n = 1'b1;
   endtask

   task automatic do_write(logic [31:0] d);
      wr_en = 1'b1; wr_data = d;
      wait_cyc(1);
      wr_en = 1'b0;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      wait_cyc(1);
      // Timeout release
      do_reset(1'b1, 1'b1, 2'b01);
      chk("R1", rd_data, 32'h0000_0086);
      chk("R2", {31'd0, cfg_retry}, 32'd1);
      chk("R2", {30'd0, core_rst}, 32'd2);
      wait_cyc(TMO - 1);
      chk("R3", {31'd0, cfg_retry}, 32'd1);
      wait_cyc(1);
      chk("R3", rd_data, 32'h0000_0002);
      wait_cyc(TMO);
      chk("R3", rd_data, 32'h0000_0002);

      // Firmware release before expiry
      do_reset(1'b1, 1'b1, 2'b01);
      wait_cyc(5);
      do_write(32'h0000_0083);
      chk("R4", rd_data, 32'h0000_0082);
      wait_cyc(TMO + 5);
      chk("R4", rd_data, 32'h0000_0082);

      // Watchdog disabled
      do_reset(1'b1, 1'b0, 2'b00);
      chk("R1", rd_data, 32'h0000_0007);
      wait_cyc(2 * TMO);
      chk("R5", {31'd0, cfg_retry}, 32'd1);
      do_write(32'h0000_0007);
      chk("R5", {31'd0, cfg_retry}, 32'd1);
      do_write(32'h0000_0001);
      chk("R6", rd_data, 32'h0000_0001);
      do_write(32'h0000_0003);
      chk("R6", rd_data, 32'h0000_0001);
      do_write(32'h0000_0201);
      chk("R7", rd_data, 32'h0000_0003);
      do_write(32'h0000_0000);
      chk("R6", {30'd0, core_rst}, 32'd0);
      bus_rst = 1'b1;
      do_write(32'h0000_0000);
      bus_rst = 1'b0;
      chk("R8", {30'd0, core_rst}, 32'd3);
      do_write(32'hFFFF_FC78);
      chk("R9", rd_data & 32'hFFFF_FC78, 32'h0000_0000);
      chk("R7", rd_data & 32'h0000_0300, 32'h0000_0000);

      // Seeded random run against the model
      void'($urandom(32'd1234));
      model_on = 1;
      for (int i = 0; i < 4000; i++) begin
         @(negedge clk);
         if (model_on && rst_n) begin
            chk("R2", {31'd0, cfg_retry}, {31'd0, m_hold});
            chk("R6", {30'd0, core_rst}, {30'd0, m_core});
            chk("R3", rd_data, exp_rd(m_hold, m_en, m_core));
         end
         rst_n   = ($urandom_range(0, 199) != 0);
         s_retry = $urandom_range(0, 3) != 0;
         s_tmr   = $urandom_range(0, 1);
         s_core_n = 2'($urandom_range(0, 3));
         bus_rst = ($urandom_range(0, 15) == 0);
         wr_en   = ($urandom_range(0, 15) == 0);
         wr_data = $urandom;
         if (wr_data[4]) wr_data[2] = 1'b1;
         if (wr_data[5]) wr_data[7] = 1'b1;
      end
      @(negedge clk);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule